// File: doc/BRIEF.md
# Low-Voltage Reset Sequencer

This block produces the internal chip reset from two sources. The first is an active-low external reset pin. The second is a digital low-voltage flag from a supply comparator. A low-voltage condition only counts as a reset request once it has stayed asserted for more than one full period of a 1 ms time-base tick. Shorter dips are discarded.

The two requests are ORed. Once neither is active, the reset output stays high for a fixed oscillator settling count before the chip runs. A sticky flag tells software whether the latest reset entry came from the low-voltage path. Software clears that flag with a one-cycle write-one-to-clear pulse.

The block leaves its asynchronous power-on reset in the reset-holding state. The chip therefore also sees the full settling count at power-up.

Top module: `lv_reset_seq`

## Requirements
- R1: While `rst_ni` is low, and after its release until the settling count has finished, `sys_rst_o` is 1 and `lv_cause_o` is 0. With the pin high and no low-voltage flag, `sys_rst_o` falls after the 3 + STAB_CYCLES rising edge following release (1027 with defaults).
- R2: The external pin is active low and passes through a two-stage synchronizer. `sys_rst_o` rises after the third rising edge that samples the pin low, and it is still 0 after the second.
- R3: While `lv_det_i` stays 1, each `tick_1ms_i` pulse is counted. The pulse that brings the count to QUAL_TICKS + 1 (2 with defaults) arms the low-voltage request, and `sys_rst_o` rises one edge later. After only QUAL_TICKS pulses, `sys_rst_o` stays 0.
- R4: Whenever `lv_det_i` is 0, the tick count is cleared. Dips that each see fewer qualifying ticks never reset the chip, however many of them occur. Ticks while `lv_det_i` is 0 have no effect.
- R5: The reset request is the OR of the synchronized external reset and the qualified low-voltage request. `sys_rst_o` stays 1 while either is active.
- R6: After the last active source clears, `sys_rst_o` stays 1 for exactly STAB_CYCLES further edges of the settling window, then falls. For the pin, that is 3 + STAB_CYCLES edges after the pin rises. For the low-voltage flag, it is 2 + STAB_CYCLES edges after the flag falls.
- R7: If any source reasserts during the settling window, the window is abandoned. A full STAB_CYCLES window starts again after that source clears.
- R8: Every entry into the reset-holding state loads `lv_cause_o` with whether the qualified low-voltage request was active. Entry caused by the pin alone therefore clears the flag, and low-voltage entry sets it.
- R9: A 1 on `cause_clr_i` clears `lv_cause_o` at the next edge, unless a reset entry loads it in that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_ni | input | 1 | External reset pin, active low, asynchronous |
| lv_det_i | input | 1 | Synchronous low-voltage detect flag, 1 = supply low |
| tick_1ms_i | input | 1 | One-cycle pulse once per millisecond |
| cause_clr_i | input | 1 | Write-one-to-clear strobe for the cause flag |
| sys_rst_o | output | 1 | Internal chip reset, active high |
| lv_cause_o | output | 1 | Sticky: latest reset entry was low-voltage |

## Verification
A tick count that is not cleared when the flag drops shows up as a reset after a second short dip. That is visible one edge after the tick that should have been harmless. A settling counter that does not restart moves the falling edge of `sys_rst_o` earlier than the full window after the last release. The bench watches for that exact cycle. A wrong cause update shows on `lv_cause_o` within one edge of the reset entry or the clear strobe.

// File: rtl/lvr_pkg.sv
package lvr_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_LV_QUAL = 2'd1,
    ST_HOLD    = 2'd2,
    ST_STAB    = 2'd3
  } lvr_state_e;
endpackage

// File: rtl/lvr_sync2.sv
// Two-stage synchronizer; both stages reset to 0 (pin reads as asserted).
module lvr_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/lvr_qualifier.sv
// Counts millisecond ticks while the low-voltage flag is held; arms a
// request on tick number QUAL_TICKS+1 and drops it when the flag clears.
module lvr_qualifier #(
  parameter int unsigned QUAL_TICKS = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lv_i,
  input  logic tick_i,
  output logic req_o
);
  localparam int unsigned QW = $clog2(QUAL_TICKS + 2);
  localparam logic [QW-1:0] ARM_AT = QW'(QUAL_TICKS);

  logic [QW-1:0] cnt_q, cnt_d;
  logic          req_q, req_d;
  logic          cnt_en;

  assign cnt_en = lv_i && tick_i && !req_q;

  always_comb begin
    cnt_d = cnt_q;
    req_d = req_q;
    if (!lv_i) begin
      cnt_d = '0;
      req_d = 1'b0;
    end else if (cnt_en) begin
      if (cnt_q == ARM_AT) begin
        req_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/lvr_stab_timer.sv
// Settling counter: runs while enabled, restarts from zero when disabled.
module lvr_stab_timer #(
  parameter int unsigned CYCLES = 1024
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        en_i,
  output logic                        done_o,
  output logic [$clog2(CYCLES)-1:0]   cnt_o
);
  localparam int unsigned CW = $clog2(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (en_i) cnt_d = cnt_q + 1'b1;
    else      cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign done_o = en_i && (cnt_q == LAST);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/lv_reset_seq.sv
module lv_reset_seq #(
  parameter int unsigned STAB_CYCLES = 1024,
  parameter int unsigned QUAL_TICKS  = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_rst_ni,
  input  logic lv_det_i,
  input  logic tick_1ms_i,
  input  logic cause_clr_i,
  output logic sys_rst_o,
  output logic lv_cause_o
);
  import lvr_pkg::*;

  localparam int unsigned CW = $clog2(STAB_CYCLES);

  lvr_state_e    state_q, state_d;
  logic          pin_sync;
  logic          ext_active;
  logic          lv_req;
  logic          stab_en;
  logic          stab_done;
  logic [CW-1:0] stab_cnt;
  logic          enter_hold;
  logic          cause_q, cause_d;

  lvr_sync2 u_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ext_rst_ni),
    .q_o   (pin_sync)
  );
  assign ext_active = !pin_sync;

  lvr_qualifier #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lv_i  (lv_det_i),
    .tick_i(tick_1ms_i),
    .req_o (lv_req)
  );

  assign stab_en = (state_q == ST_STAB);

  lvr_stab_timer #(.CYCLES(STAB_CYCLES)) u_stab (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (stab_en),
    .done_o(stab_done),
    .cnt_o (stab_cnt)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_NORMAL: begin
        if (ext_active || lv_req) state_d = ST_HOLD;
        else if (lv_det_i)        state_d = ST_LV_QUAL;
      end
      ST_LV_QUAL: begin
        if (ext_active || lv_req) state_d = ST_HOLD;
        else if (!lv_det_i)       state_d = ST_NORMAL;
      end
      ST_HOLD: begin
        if (!ext_active && !lv_req) state_d = ST_STAB;
      end
      ST_STAB: begin
        if (ext_active || lv_req) state_d = ST_HOLD;
        else if (stab_done)       state_d = ST_NORMAL;
      end
      default: state_d = ST_HOLD;
    endcase
  end

  assign enter_hold = (state_d == ST_HOLD) && (state_q != ST_HOLD);

  always_comb begin
    cause_d = cause_q;
    if (enter_hold)       cause_d = lv_req;
    else if (cause_clr_i) cause_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      cause_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cause_q <= cause_d;
    end
  end

  assign sys_rst_o  = (state_q == ST_HOLD) || (state_q == ST_STAB);
  assign lv_cause_o = cause_q;
endmodule

// File: rtl/lv_reset_seq_chk.sv
module lv_reset_seq_chk #(
  parameter int unsigned STAB_CYCLES = 1024
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             lv_det_i,
  input logic                             cause_clr_i,
  input logic                             sys_rst_o,
  input logic                             lv_cause_o,
  input logic                             ext_active_i,
  input logic                             lv_req_i,
  input logic [$clog2(STAB_CYCLES)-1:0]   stab_cnt_i
);
  p_pin_holds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_active_i |=> sys_rst_o);

  p_lv_req_resets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lv_req_i |=> sys_rst_o);

  p_req_needs_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lv_req_i) |-> $past(lv_det_i));

  p_full_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> ($past(stab_cnt_i) == ($clog2(STAB_CYCLES))'(STAB_CYCLES - 1)));

  p_cause_in_reset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lv_cause_o) |-> sys_rst_o);

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_clr_i && !lv_req_i) |=> !lv_cause_o);
endmodule

bind lv_reset_seq lv_reset_seq_chk #(.STAB_CYCLES(STAB_CYCLES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lv_det_i    (lv_det_i),
  .cause_clr_i (cause_clr_i),
  .sys_rst_o   (sys_rst_o),
  .lv_cause_o  (lv_cause_o),
  .ext_active_i(ext_active),
  .lv_req_i    (lv_req),
  .stab_cnt_i  (stab_cnt)
);

// File: tb/lv_reset_seq_bench.sv
module lv_reset_seq_bench;
  localparam int STAB = 1024;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_ni, ext_rst_ni, lv_det_i, tick_1ms_i, cause_clr_i;
  logic sys_rst_o, lv_cause_o;

  always #10 clk = ~clk;  // 50 MHz

  lv_reset_seq #(.STAB_CYCLES(STAB), .QUAL_TICKS(1)) u_lv_reset_seq (
    .clk_i(clk), .rst_ni(rst_ni), .ext_rst_ni(ext_rst_ni), .lv_det_i(lv_det_i),
    .tick_1ms_i(tick_1ms_i), .cause_clr_i(cause_clr_i),
    .sys_rst_o(sys_rst_o), .lv_cause_o(lv_cause_o)
  );

  typedef struct {
    int    stamp;
    logic  rst;
    logic  cause;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(input int delay, input logic r, input logic c, input string tag);
    exp_t e;
    e.stamp = cyc + delay; e.rst = r; e.cause = c; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: pops due expectations and compares at the falling edge.
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].stamp <= cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      total++;
      if (e.stamp < cyc || sys_rst_o !== e.rst || lv_cause_o !== e.cause) begin
        bad++;
        $display("FAIL %s cyc=%0d: rst=%b cause=%b expected rst=%b cause=%b",
                 e.tag, e.stamp, sys_rst_o, lv_cause_o, e.rst, e.cause);
      end
    end
  end

  always @(negedge clk) begin
    if (!done && cyc > WATCHDOG) begin
      total++; bad++;
      $display("FAIL watchdog: actual cyc=%0d expected below %0d", cyc, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain;
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_tick;
    tick_1ms_i = 1'b1;
    step(1);
    tick_1ms_i = 1'b0;
  endtask

  initial begin
    rst_ni = 1'b0; ext_rst_ni = 1'b1; lv_det_i = 1'b0;
    tick_1ms_i = 1'b0; cause_clr_i = 1'b0;
    step(3);
    // R1: state during power-on reset
    total++;
    if (sys_rst_o !== 1'b1 || lv_cause_o !== 1'b0) begin
      bad++;
      $display("FAIL R1 in reset: rst=%b cause=%b expected rst=1 cause=0", sys_rst_o, lv_cause_o);
    end
    rst_ni = 1'b1;
    expect_at(2, 1'b1, 1'b0, "R1 early");
    expect_at(2 + STAB, 1'b1, 1'b0, "R1 last reset cycle");
    expect_at(3 + STAB, 1'b0, 1'b0, "R1 released");
    drain();

    // R2/R6: external pin reset
    ext_rst_ni = 1'b0;
    expect_at(2, 1'b0, 1'b0, "R2 still synchronizing");
    expect_at(3, 1'b1, 1'b0, "R2 asserted");
    drain();
    step(3);
    ext_rst_ni = 1'b1;
    expect_at(2 + STAB, 1'b1, 1'b0, "R6 pin window last cycle");
    expect_at(3 + STAB, 1'b0, 1'b0, "R6 pin window done");
    drain();

    // R3: qualification by two ticks while flag is held
    lv_det_i = 1'b1;
    step(3);
    pulse_tick();
    step(5);
    expect_at(1, 1'b0, 1'b0, "R3 one tick only");
    pulse_tick();
    expect_at(1, 1'b1, 1'b1, "R3 reset after qualifying tick");
    drain();
    step(4);
    lv_det_i = 1'b0;
    expect_at(1 + STAB, 1'b1, 1'b1, "R6 lv window last cycle");
    expect_at(2 + STAB, 1'b0, 1'b1, "R6 lv window done");
    drain();

    // R9: write-one-to-clear
    cause_clr_i = 1'b1;
    step(1);
    cause_clr_i = 1'b0;
    expect_at(0, 1'b0, 1'b0, "R9 cause cleared");
    drain();

    // R4: short dips, counter cleared between them; ticks with flag low ignored
    lv_det_i = 1'b1; step(2); pulse_tick(); step(2);
    lv_det_i = 1'b0; step(2); pulse_tick(); step(2);
    lv_det_i = 1'b1; step(2); pulse_tick(); step(2);
    lv_det_i = 1'b0;
    expect_at(1, 1'b0, 1'b0, "R4 no reset after dips");
    expect_at(10, 1'b0, 1'b0, "R4 still running");
    drain();

    // R5/R8: LV reset, then pin joins; reset holds until pin releases
    lv_det_i = 1'b1; pulse_tick(); step(2); pulse_tick();
    expect_at(1, 1'b1, 1'b1, "R8 lv entry sets cause");
    drain();
    ext_rst_ni = 1'b0;
    step(3);
    lv_det_i = 1'b0;
    step(1100);
    expect_at(1, 1'b1, 1'b1, "R5 pin alone holds reset");
    drain();
    ext_rst_ni = 1'b1;
    expect_at(3 + STAB, 1'b0, 1'b1, "R5 released after both");
    drain();

    // R8: pin-only entry clears cause; R7: reassert restarts window
    ext_rst_ni = 1'b0;
    expect_at(3, 1'b1, 1'b0, "R8 pin entry clears cause");
    step(4);
    ext_rst_ni = 1'b1;
    drain();
    step(500);
    ext_rst_ni = 1'b0;
    step(4);
    ext_rst_ni = 1'b1;
    expect_at(600, 1'b1, 1'b0, "R7 old window end ignored");
    expect_at(2 + STAB, 1'b1, 1'b0, "R7 new window last cycle");
    expect_at(3 + STAB, 1'b0, 1'b0, "R7 new window done");
    drain();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule